// File: doc/BRIEF.md
# Dual-Mode Serial Transmit Controller

This block serializes one byte held in a transmit buffer onto a single data line. It runs in one of two modes chosen by a configuration input. In UART mode, a free-running 4-bit counter divides the serial base-clock enable by 16 to form a bit tick. Each frame is a start bit, eight data bits sent least significant bit first, and a stop bit, and it starts on the first tick after the buffer write. In synchronous mode the same shifter moves one data bit per shift-clock edge. That shift clock is either made inside the block from the base enable and driven out, or taken from an external pin through a two-flop synchronizer.

An edge-select input chooses whether data changes on the rising or the falling shift-clock edge. A busy output covers the whole transfer, and a buffer write while busy is dropped. Baud prescaling sits upstream and only appears here as the base enable.

Top module: `dual_tx_ctrl`

## Requirements
- R1: After reset, and whenever no transfer runs, `txd_o` is 1 and `busy_o` is 0. After reset `sclk_o` is 1.
- R2: The UART bit tick is one base enable in 16. The k-th tick is the 16k-th base enable counted from reset, and the counter runs in every mode.
- R3: In UART mode, a write taken at a clock edge starts the start bit on the first tick after that edge. A tick on the write edge itself does not count.
- R4: A UART frame is 0, then data bit 0 through bit 7, then 1, with each bit lasting one tick period. `busy_o` falls on the tick that ends the stop bit.
- R5: In synchronous mode with `clk_ext_i`=0, `sclk_o` toggles once per base enable while busy, starting from high. Each active edge puts the next data bit on `txd_o`, least significant bit first. A transfer makes 18 toggles in total, and `sclk_o` rests high afterwards.
- R6: In synchronous mode with `clk_ext_i`=1, each active edge of `ext_sclk_i`, after a two-flop synchronizer, advances the data. `sclk_o` stays high.
- R7: With `edge_fall_i`=1 data changes on falling shift-clock edges. With `edge_fall_i`=0 it changes on rising edges.
- R8: `busy_o` rises on the clock after an accepted write. A write while `busy_o` is 1 has no effect on the frame being sent and starts no later frame.
- R9: In synchronous mode the 9th active edge returns `txd_o` to 1 and clears `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_en_i | input | 1 | Serial base-clock enable, one cycle wide |
| mode_uart_i | input | 1 | 1 selects UART mode, 0 selects synchronous mode |
| clk_ext_i | input | 1 | Synchronous mode: 1 takes the shift clock from `ext_sclk_i`, 0 generates it |
| edge_fall_i | input | 1 | 1 means data changes on the falling shift-clock edge, 0 on the rising edge |
| wr_i | input | 1 | Transmit buffer write strobe |
| wr_data_i | input | 8 | Byte to transmit |
| ext_sclk_i | input | 1 | External shift clock (asynchronous) |
| txd_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Driven shift clock |
| busy_o | output | 1 | Transfer in progress |

## Verification
The assertions take the mode, clock-source and edge-select inputs to be steady while `busy_o` is high, and they check that this holds. They also take the external shift clock to change more slowly than the synchronizer plus edge detector can follow. The stimulus changes configuration only between frames, after `busy_o` has fallen. It drives the external clock with half-periods of ten system cycles. In generated-clock mode it spaces base enables eight cycles apart, so each data bit can be sampled well after the edge that changes it.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [1:0] {
    TXM_UART    = 2'd0,
    TXM_SYNC_IN = 2'd1,
    TXM_SYNC_EX = 2'd2
  } tx_mode_e;

  function automatic tx_mode_e decode_mode(input logic uart, input logic ext);
    if (uart) return TXM_UART;
    return ext ? TXM_SYNC_EX : TXM_SYNC_IN;
  endfunction
endpackage

// File: rtl/tx_baud_div.sv
module tx_baud_div #(
  parameter int DIV_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam logic [DIV_W-1:0] CNT_MAX = '1;

  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (en_i) cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == CNT_MAX);

  // R2: ticks are at least 2^DIV_W enables apart, so never back to back
  a_r2_no_adjacent_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tx_sclk_unit.sv
module tx_sclk_unit #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic base_en_i,
  input  logic gen_run_i,
  input  logic use_ext_i,
  input  logic ext_sclk_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int LAST = SYNC_STAGES - 1;

  // internal clock generator: toggles while running, or to return to high
  logic sclk_q, gen_step;
  assign gen_step = base_en_i && (gen_run_i || !sclk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sclk_q <= 1'b1;
    else if (gen_step) sclk_q <= ~sclk_q;
  end

  // external clock synchronizer and edge history
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[LAST-1:0], ext_sclk_i};
      hist_q <= sync_q[LAST];
    end
  end

  logic int_rise, int_fall, ext_rise, ext_fall;
  assign int_rise = gen_step && !sclk_q;
  assign int_fall = gen_step &&  sclk_q;
  assign ext_rise =  sync_q[LAST] && !hist_q;
  assign ext_fall = !sync_q[LAST] &&  hist_q;

  assign sclk_o = sclk_q;
  assign rise_o = use_ext_i ? ext_rise : int_rise;
  assign fall_o = use_ext_i ? ext_fall : int_fall;

  // R7: one edge kind per cycle
  a_r7_single_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rise_o, fall_o}));
  // R5: a stopped generator that rests high stays high
  a_r5_rest_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gen_run_i && sclk_q) |=> sclk_q);
endmodule

// File: rtl/tx_shift_core.sv
module tx_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              uart_i,
  input  logic              step_i,
  output logic              txd_o,
  output logic              busy_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] N_UART = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] N_SYNC = CNT_W'(DATA_W);

  logic [FRAME_W-1:0] sr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               busy_q, txd_q, uart_q;
  logic [CNT_W-1:0]   n_bits;

  assign n_bits = uart_q ? N_UART : N_SYNC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      uart_q <= 1'b0;
    end else if (!busy_q) begin
      if (wr_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        uart_q <= uart_i;
        sr_q   <= uart_i ? {1'b1, wr_data_i, 1'b0} : {2'b11, wr_data_i};
      end
    end else if (step_i) begin
      if (cnt_q == n_bits) begin
        busy_q <= 1'b0;
        txd_q  <= 1'b1;
      end else begin
        txd_q <= sr_q[0];
        sr_q  <= {1'b1, sr_q[FRAME_W-1:1]};
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign txd_o  = txd_q;
  assign busy_o = busy_q;

  a_r1_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> txd_q);
  a_r8_busy_from_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(wr_i));
  a_r8_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && wr_i && !step_i) |=> ($stable(sr_q) && $stable(cnt_q)));
  a_r3_line_moves_on_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(txd_q) |-> $past(step_i));
  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= N_UART);
endmodule

// File: rtl/dual_tx_ctrl.sv
module dual_tx_ctrl #(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_en_i,
  input  logic              mode_uart_i,
  input  logic              clk_ext_i,
  input  logic              edge_fall_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ext_sclk_i,
  output logic              txd_o,
  output logic              sclk_o,
  output logic              busy_o
);
  import tx_pkg::*;

  tx_mode_e mode;
  logic     tick, rise, fall, step, busy, gen_run;

  assign mode    = decode_mode(mode_uart_i, clk_ext_i);
  assign gen_run = busy && (mode == TXM_SYNC_IN);

  tx_baud_div #(.DIV_W(DIV_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (base_en_i),
    .tick_o (tick)
  );

  tx_sclk_unit #(.SYNC_STAGES(SYNC_STAGES)) i_sclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .base_en_i  (base_en_i),
    .gen_run_i  (gen_run),
    .use_ext_i  (mode == TXM_SYNC_EX),
    .ext_sclk_i (ext_sclk_i),
    .sclk_o     (sclk_o),
    .rise_o     (rise),
    .fall_o     (fall)
  );

  always_comb begin
    unique case (mode)
      TXM_UART: step = tick;
      default:  step = edge_fall_i ? fall : rise;
    endcase
  end

  tx_shift_core #(.DATA_W(DATA_W)) i_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .uart_i    (mode_uart_i),
    .step_i    (step),
    .txd_o     (txd_o),
    .busy_o    (busy)
  );

  assign busy_o = busy;

  // R8: configuration is held steady for the length of a transfer
  a_r8_cfg_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> ($stable(mode_uart_i) && $stable(clk_ext_i) && $stable(edge_fall_i)));
  // R6: an external clock never drives the clock pin
  a_r6_pin_quiet_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == TXM_SYNC_EX && sclk_o) |=> sclk_o);
endmodule

// File: tb/test_dual_tx_ctrl.sv
module test_dual_tx_ctrl;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       base_en_i = 1'b0, mode_uart_i = 1'b1, clk_ext_i = 1'b0, edge_fall_i = 1'b0;
  logic       wr_i = 1'b0, ext_sclk_i = 1'b1;
  logic [7:0] wr_data_i = 8'h00;
  logic       txd_o, sclk_o, busy_o;

  dual_tx_ctrl i_dual_tx_ctrl (.*);

  always #2.5 clk_i = ~clk_i;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // base enable generator and enable counter
  int en_period = 1, en_div = 0, bcnt = 0;
  always @(posedge clk_i) begin
    if (rst_ni && base_en_i) bcnt <= bcnt + 1;
    #1;
    en_div    = (en_div + 1 >= en_period) ? 0 : en_div + 1;
    base_en_i = rst_ni && (en_div == 0);
  end

  int sclk_toggles = 0;
  logic sclk_prev = 1'b1;
  always @(negedge clk_i) begin
    if (sclk_o != sclk_prev) sclk_toggles++;
    sclk_prev = sclk_o;
  end

  // scoreboard
  logic exp_q[$];
  bit   uart_armed = 0, sync_armed = 0, frame_done = 0;
  int   exp_start = 0;

  // UART monitor
  always @(negedge clk_i) begin
    if (uart_armed && mode_uart_i && txd_o == 1'b0) begin
      uart_armed = 0;
      chk("R2 start aligned to 16 enables", bcnt % 16, 0);
      chk("R3 start on first tick after write", bcnt, exp_start);
      repeat (8 * en_period) @(negedge clk_i);
      chk("R4 start bit", int'(txd_o), 0);
      while (exp_q.size() > 0) begin
        logic e;
        repeat (16 * en_period) @(negedge clk_i);
        e = exp_q.pop_front();
        chk("R4 data bit lsb first", int'(txd_o), int'(e));
      end
      repeat (16 * en_period) @(negedge clk_i);
      chk("R4 stop bit", int'(txd_o), 1);
      chk("R4 busy during stop", int'(busy_o), 1);
      repeat (8 * en_period + 2) @(negedge clk_i);
      chk("R4 busy ends after stop", int'(busy_o), 0);
      frame_done = 1;
    end
  end

  // synchronous monitor
  logic obs_prev = 1'b1;
  always @(negedge clk_i) begin
    logic obs;
    logic active;
    obs    = clk_ext_i ? ext_sclk_i : sclk_o;
    active = edge_fall_i ? (obs_prev && !obs) : (!obs_prev && obs);
    obs_prev = obs;
    if (sync_armed && !mode_uart_i && active) begin
      repeat (4) @(negedge clk_i);
      if (exp_q.size() > 0) begin
        logic e;
        e = exp_q.pop_front();
        chk("R5 R6 R7 sync data bit", int'(txd_o), int'(e));
        chk("R8 busy mid transfer", int'(busy_o), 1);
      end else begin
        chk("R9 line high after 9th edge", int'(txd_o), 1);
        chk("R9 busy clear after 9th edge", int'(busy_o), 0);
        sync_armed = 0;
        frame_done = 1;
      end
    end
  end

  task automatic push_bits(logic [7:0] d);
    for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
  endtask

  task automatic write_byte(logic [7:0] d);
    @(posedge clk_i); #1;
    wr_i = 1'b1; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
  endtask

  task automatic uart_frame(logic [7:0] d, int per, bit extra_wr);
    en_period = per;
    mode_uart_i = 1'b1;
    frame_done = 0;
    push_bits(d);
    uart_armed = 1;
    @(posedge clk_i); #1;
    wr_i = 1'b1; wr_data_i = d;
    @(posedge clk_i); #1;
    wr_i = 1'b0;
    exp_start = (bcnt / 16 + 1) * 16;
    @(negedge clk_i);
    chk("R8 busy after write", int'(busy_o), 1);
    if (extra_wr) begin
      repeat (20 * per) @(posedge clk_i);
      write_byte(~d);   // R8: dropped while busy
    end
    wait (frame_done);
    repeat (40 * per) @(negedge clk_i);
    chk("R8 no frame from dropped write (txd)", int'(txd_o), 1);
    chk("R8 no frame from dropped write (busy)", int'(busy_o), 0);
  endtask

  task automatic sync_int_frame(logic [7:0] d, logic fall_sel);
    en_period = 8;
    mode_uart_i = 1'b0; clk_ext_i = 1'b0; edge_fall_i = fall_sel;
    repeat (20) @(posedge clk_i);
    frame_done = 0;
    push_bits(d);
    sync_armed = 1;
    sclk_toggles = 0;
    write_byte(d);
    wait (frame_done);
    repeat (40) @(negedge clk_i);
    chk("R5 toggles per transfer", sclk_toggles, 18);
    chk("R5 clock rests high", int'(sclk_o), 1);
  endtask

  task automatic sync_ext_frame(logic [7:0] d, logic fall_sel);
    en_period = 1;
    mode_uart_i = 1'b0; clk_ext_i = 1'b1; edge_fall_i = fall_sel;
    repeat (5) @(posedge clk_i);
    frame_done = 0;
    push_bits(d);
    sync_armed = 1;
    sclk_toggles = 0;
    write_byte(d);
    for (int t = 0; t < 18; t++) begin
      repeat (10) @(posedge clk_i);
      #1 ext_sclk_i = ~ext_sclk_i;
    end
    repeat (12) @(negedge clk_i);
    chk("R6 transfer finished", int'(frame_done), 1);
    chk("R6 clock pin untouched", sclk_toggles, 0);
    sync_armed = 0;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 reset txd", int'(txd_o), 1);
    chk("R1 reset sclk", int'(sclk_o), 1);
    chk("R1 reset busy", int'(busy_o), 0);
    #1 rst_ni = 1'b1;
    repeat (7) @(posedge clk_i);

    uart_frame(8'hA5, 1, 1'b1);
    uart_frame(8'h01, 2, 1'b0);
    uart_frame(8'hFE, 1, 1'b0);
    sync_int_frame(8'h96, 1'b0);
    sync_int_frame(8'h5B, 1'b1);
    sync_ext_frame(8'hC3, 1'b0);
    sync_ext_frame(8'h7E, 1'b1);

    @(negedge clk_i);
    chk("R1 idle txd", int'(txd_o), 1);
    chk("R1 idle busy", int'(busy_o), 0);
    finish_run();
  end
endmodule